// File: doc/BRIEF.md
# PLL Lock Monitor with Unlock Event Counter

This block judges whether an external PLL is in lock. It samples the 40 MHz clock that the monitored device produces on every falling edge of the reference clock. The samples pass through a two-flop synchronizer and drive a three-state hysteretic filter. A sampled 1 means the two clocks are in phase. A sampled 0 means they are out of phase.

The states are ST_WAIT (waiting for lock), ST_LOCKED and ST_CONFIRM (a possible loss is being judged). The transitions are T_ACQUIRE (ST_WAIT to ST_LOCKED), T_SUSPECT (ST_LOCKED to ST_CONFIRM), T_CANCEL (ST_CONFIRM back to ST_LOCKED) and T_DROP (ST_CONFIRM to ST_WAIT). The filter declares lock only after a long unbroken run of good samples. A single bad sample only raises a suspicion. That suspicion is then confirmed by an accumulated count of bad samples, or withdrawn by a shorter unbroken run of good samples.

Every confirmed loss (T_DROP) adds one to a saturating event counter. Radiation upset tests read this counter to see how often lock was really lost. Withdrawn suspicions are not counted.

Top module: `pll_lock_monitor`

## Requirements
- R1: While rst_n is low and after its release, lock_det is 0, unlock_count is 0 and the machine is in ST_WAIT.
- R2: dev_clk_in is captured on the falling edge of ref_clk and passes through two synchronizer flops. A sample that is stable across falling edge n is acted on by the machine at falling edge n+2.
- R3: In ST_WAIT, lock_det is 0. 2^ACQ_W consecutive 1 samples take T_ACQUIRE. Any 0 sample restarts that run from zero.
- R4: In ST_LOCKED, lock_det is 1. A single 0 sample takes T_SUSPECT, and both confirm counters start from zero. The 0 sample that triggered the move is not counted as a bad sample.
- R5: In ST_CONFIRM, lock_det stays 1. Every 0 sample adds to the bad count, whether or not the 0 samples are consecutive.
- R6: When the 2^CONF_W-th 0 sample arrives in ST_CONFIRM, T_DROP is taken. lock_det falls to 0 and unlock_count increases by one.
- R7: 2^CONF_W consecutive 1 samples in ST_CONFIRM take T_CANCEL, and unlock_count does not change. A 0 sample clears that run of good samples.
- R8: unlock_count is CNT_W bits wide. It saturates at all ones instead of wrapping, and it changes only on T_DROP or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_clk_in | input | 1 | 40 MHz clock from the monitored device, the sampled signal |
| lock_det | output | 1 | 1 in ST_LOCKED and ST_CONFIRM, 0 in ST_WAIT |
| unlock_count | output | CNT_W | Saturating count of confirmed lock losses |

## Verification
The bench builds the block with ACQ_W=4, CONF_W=3 and CNT_W=3. Lock therefore needs 16 good samples, and a confirm decision needs 8 samples. The counter saturates at 7 after only seven drops, so every transition and its exact boundary (one sample short, and exactly enough) can be reached in a few dozen cycles. The small counter also lets the bench drive the saturation corner directly, with repeated acquire and drop cycles, instead of running 65535 of them.

// File: rtl/pll_lock_monitor_pkg.sv
package pll_lock_monitor_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_CONFIRM = 2'd2
    } lock_state_t;

endpackage

// File: rtl/plm_sync.sv
module plm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_n_edge,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(negedge clk_n_edge or negedge rst_n) begin
                    if (!rst_n) pipe_q[g] <= 1'b0;
                    else        pipe_q[g] <= d_in;
                end
            end else begin : g_rest
                always_ff @(negedge clk_n_edge or negedge rst_n) begin
                    if (!rst_n) pipe_q[g] <= 1'b0;
                    else        pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign q_out = pipe_q[STAGES-1];

endmodule

// File: rtl/plm_fsm.sv
module plm_fsm
    import pll_lock_monitor_pkg::*;
#(
    parameter int ACQ_W  = 10,
    parameter int CONF_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp,
    output logic lock_o,
    output logic drop_o
);

    localparam logic [ACQ_W-1:0]  RUN_MAX  = {ACQ_W{1'b1}};
    localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

    lock_state_t       state_q, state_d;
    logic [ACQ_W-1:0]  run_q, run_d;
    logic [CONF_W-1:0] good_q, good_d;
    logic [CONF_W-1:0] bad_q, bad_d;

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        good_d  = good_q;
        bad_d   = bad_q;
        unique case (state_q)
            ST_WAIT: begin
                if (!samp) begin
                    run_d = '0;
                end else if (run_q == RUN_MAX) begin
                    state_d = ST_LOCKED;          // T_ACQUIRE
                    run_d   = '0;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
            ST_LOCKED: begin
                if (!samp) begin
                    state_d = ST_CONFIRM;         // T_SUSPECT
                    good_d  = '0;
                    bad_d   = '0;
                end
            end
            ST_CONFIRM: begin
                if (samp) begin
                    if (good_q == CONF_MAX) begin
                        state_d = ST_LOCKED;      // T_CANCEL
                        good_d  = '0;
                        bad_d   = '0;
                    end else begin
                        good_d = good_q + 1'b1;
                    end
                end else begin
                    good_d = '0;
                    if (bad_q == CONF_MAX) begin
                        state_d = ST_WAIT;        // T_DROP
                        bad_d   = '0;
                        run_d   = '0;
                    end else begin
                        bad_d = bad_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_WAIT;
                run_d   = '0;
                good_d  = '0;
                bad_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            run_q   <= '0;
            good_q  <= '0;
            bad_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            good_q  <= good_d;
            bad_q   <= bad_d;
        end
    end

    // Outputs
    always_comb begin
        lock_o = 1'b0;
        drop_o = 1'b0;
        unique case (state_q)
            ST_WAIT:    lock_o = 1'b0;
            ST_LOCKED:  lock_o = 1'b1;
            ST_CONFIRM: begin
                lock_o = 1'b1;
                drop_o = !samp && (bad_q == CONF_MAX);
            end
            default:    lock_o = 1'b0;
        endcase
    end

    a_r3_acquire_on_good: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(samp));

    a_r4_suspect_on_bad: assert property (@(negedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !samp) |=> (state_q == ST_CONFIRM && lock_o));

    a_r5_confirm_holds_lock: assert property (@(negedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIRM && !drop_o) |=> lock_o);

    a_r6_fall_only_by_drop: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(drop_o));

    a_r7_good_never_drops: assert property (@(negedge clk) disable iff (!rst_n)
        samp |-> !drop_o);

endmodule

// File: rtl/plm_event_ctr.sv
module plm_event_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (inc && count != CNT_MAX) count <= count + CNT_ONE;
    end

    a_r6_step_on_drop: assert property (@(negedge clk) disable iff (!rst_n)
        (inc && count != CNT_MAX) |=> (count == $past(count) + CNT_ONE));

    a_r8_saturate: assert property (@(negedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    a_r8_only_on_drop: assert property (@(negedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
    parameter int ACQ_W       = 10,
    parameter int CONF_W      = 7,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             dev_clk_in,
    output logic             lock_det,
    output logic [CNT_W-1:0] unlock_count
);

    logic samp_s;
    logic drop_w;

    plm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_n_edge (ref_clk),
        .rst_n      (rst_n),
        .d_in       (dev_clk_in),
        .q_out      (samp_s)
    );

    plm_fsm #(.ACQ_W(ACQ_W), .CONF_W(CONF_W)) u_fsm (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .samp   (samp_s),
        .lock_o (lock_det),
        .drop_o (drop_w)
    );

    plm_event_ctr #(.W(CNT_W)) u_ctr (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .inc   (drop_w),
        .count (unlock_count)
    );

    a_r1_reset_state: assert property (@(negedge ref_clk)
        !rst_n |=> (!lock_det && unlock_count == '0));

endmodule

// File: tb/tb_pll_lock_monitor.sv
module tb_pll_lock_monitor;

    localparam int ACQ_W  = 4;
    localparam int CONF_W = 3;
    localparam int CNT_W  = 3;
    localparam int ACQ_N  = 1 << ACQ_W;
    localparam int CONF_N = 1 << CONF_W;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic             ref_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic             dev_clk_in = 1'b0;
    logic             lock_det;
    logic [CNT_W-1:0] unlock_count;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #5 ref_clk = ~ref_clk;

    pll_lock_monitor #(.ACQ_W(ACQ_W), .CONF_W(CONF_W), .CNT_W(CNT_W)) dut (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .dev_clk_in   (dev_clk_in),
        .lock_det     (lock_det),
        .unlock_count (unlock_count)
    );

    task automatic push(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge ref_clk);
            dev_clk_in = v;
        end
    endtask

    // Let the last pushed sample reach the machine (R2 latency), then settle
    task automatic flush(input logic fill);
        push(fill, 3);
        #1;
    endtask

    task automatic check(input string req, input logic exp_lock, input int exp_c);
        checks++;
        if (lock_det !== exp_lock || unlock_count !== CNT_W'(exp_c)) begin
            errors++;
            $display("FAIL %s: lock_det=%0b unlock_count=%0d expected lock_det=%0b unlock_count=%0d",
                     req, lock_det, unlock_count, exp_lock, exp_c);
        end
    endtask

    task automatic do_reset();
        @(posedge ref_clk);
        rst_n = 1'b0;
        dev_clk_in = 1'b0;
        push(1'b0, 3);
        #1;
        check("R1 during reset", 1'b0, 0);
        rst_n = 1'b1;
        exp_cnt = 0;
        flush(1'b0);
        check("R1 after release", 1'b0, 0);
    endtask

    task automatic acquire();
        push(1'b1, ACQ_N);
        flush(1'b1);
    endtask

    task automatic t_acquire_boundary();
        push(1'b1, ACQ_N - 1);
        flush(1'b0);
        check("R3 one short of lock run", 1'b0, exp_cnt);
        push(1'b1, ACQ_N - 6);
        push(1'b0, 1);
        push(1'b1, ACQ_N - 1);
        flush(1'b0);
        check("R3 zero restarts run", 1'b0, exp_cnt);
        push(1'b1, ACQ_N);
        flush(1'b1);
        check("R2 R3 lock after full run", 1'b1, exp_cnt);
    endtask

    task automatic t_cancel();
        push(1'b0, 1);
        flush(1'b1);
        check("R4 single zero keeps lock", 1'b1, exp_cnt);
        push(1'b1, CONF_N - 3);
        push(1'b0, CONF_N - 1);
        push(1'b1, CONF_N);
        push(1'b0, 1);
        push(1'b0, CONF_N - 1);
        flush(1'b1);
        check("R7 cancel returned to locked with fresh counts", 1'b1, exp_cnt);
        push(1'b1, CONF_N);
        flush(1'b1);
        check("R7 cancel leaves count", 1'b1, exp_cnt);
    endtask

    task automatic t_scattered_drop();
        push(1'b0, 1);
        for (int k = 0; k < CONF_N - 1; k++) begin
            push(1'b0, 1);
            push(1'b1, 3);
        end
        flush(1'b1);
        check("R5 R7 scattered zeros below limit", 1'b1, exp_cnt);
        push(1'b0, 1);
        flush(1'b1);
        exp_cnt++;
        check("R6 scattered zeros confirm loss", 1'b0, exp_cnt);
    endtask

    task automatic t_ones_short();
        acquire();
        check("R3 relock", 1'b1, exp_cnt);
        push(1'b0, 1);
        push(1'b1, CONF_N - 1);
        push(1'b0, CONF_N - 1);
        flush(1'b0);
        check("R4 entering zero not counted", 1'b1, exp_cnt);
        exp_cnt++;
        flush(1'b0);
        check("R7 R6 short good run does not cancel", 1'b0, exp_cnt);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < CMAX + 2; k++) begin
            acquire();
            push(1'b0, CONF_N + 1);
            flush(1'b0);
            if (exp_cnt < CMAX) exp_cnt++;
        end
        check("R8 count saturates", 1'b0, CMAX);
    endtask

    task automatic t_reset_locked();
        acquire();
        check("R3 locked before reset", 1'b1, exp_cnt);
        do_reset();
    endtask

    initial begin
        do_reset();
        t_acquire_boundary();
        t_cancel();
        t_scattered_drop();
        t_ones_short();
        t_saturate();
        t_reset_locked();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule